// File: doc/BRIEF.md
# Warp Issue Scheduler

This block decides, cycle by cycle, which thread group ("warp") feeds a row of SIMD lanes. It keeps a context for each warp slot: a valid flag, an instruction counter, a per-thread active mask, and two stall flags (short and long). A warp holds 32 threads and the row has 8 lanes, so one warp instruction takes four consecutive cycles. Each cycle carries one thread sub-group, and the per-thread mask gates the lane enables of that sub-group.

Two switch policies are available. In fine-grain mode the scheduler picks a new warp at every group boundary, rotating round-robin over the ready warps and skipping stalled ones. In coarse-grain mode it keeps the current warp until that warp reports a long stall. A short stall on the current warp leaves the lanes idle until the warp is woken again. The controller is a three-state machine. IDLE means nothing issues. ISSUE means a warp group is in flight, with a sub-group counter running 0 to 3. HOLD is the coarse-mode wait on a short-stalled current warp.

The transitions are taken only at a group boundary, which is any cycle in IDLE or HOLD, or the last sub-cycle of ISSUE:
- IDLE->ISSUE when a warp is ready.
- ISSUE->ISSUE at the end of a group when a warp is ready.
- ISSUE->IDLE when no warp is ready.
- ISSUE->HOLD in coarse mode when the owned warp is short-stalled.
- HOLD->ISSUE when the owned warp is woken.
- HOLD->ISSUE with a different warp when the owned warp is retired or long-stalled and another warp is ready.
- HOLD->IDLE when the owned warp is lost and nothing else is ready.

Top module: `warp_issue_sched`

## Requirements
- R1: During and right after reset no warp issues: issue_valid is 0 and lane_en is all zero.
- R2: A launch stores the warp's start counter, which appears on issue_pc during that warp's first group. The counter advances by one after each group the warp completes.
- R3: A group occupies four consecutive cycles with issue_sub equal to 0, 1, 2 and then 3. issue_warp and issue_pc are held for all four cycles.
- R4: In sub-cycle s, lane_en bit i equals active-mask bit 8*s+i of the issuing warp.
- R5: In fine-grain mode (coarse_mode=0) the next group goes to the first ready warp found when counting upward, with wraparound, from the warp that issued last. After reset the search starts at warp 0.
- R6: In fine-grain mode a warp whose short-stall flag is set is skipped while other ready warps issue.
- R7: In coarse-grain mode (coarse_mode=1) the current warp keeps issuing group after group while it is not long-stalled, even when other warps are ready.
- R8: In coarse-grain mode a short stall of the current warp idles the lanes without switching to another warp. After a wake, the same warp resumes at sub-cycle 0.
- R9: In coarse-grain mode a long stall of the current warp makes the scheduler switch at the next boundary to the next ready warp in round-robin order.
- R10: When no warp is ready, issue_valid is 0 and lane_en is all zero.
- R11: A new warp is chosen only at a group boundary. A stall raised in the middle of a group does not cut that group short.
- R12: A retired warp is no longer issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_mode | input | 1 | 0 selects fine-grain, 1 selects coarse-grain switching |
| launch_en | input | 1 | Load a context and make it valid |
| launch_id | input | 5 | Warp slot to load |
| launch_pc | input | 16 | Start instruction counter |
| launch_mask | input | 32 | Per-thread active mask |
| retire_en | input | 1 | Invalidate a context |
| retire_id | input | 5 | Warp slot to invalidate |
| stall_en | input | 1 | Raise a stall flag |
| stall_id | input | 5 | Warp slot that stalls |
| stall_long | input | 1 | 1 raises the long-stall flag, 0 the short-stall flag |
| wake_en | input | 1 | Clear both stall flags |
| wake_id | input | 5 | Warp slot to wake |
| issue_valid | output | 1 | A warp group is issuing; 0 is the idle indication |
| issue_warp | output | 5 | Issuing warp slot |
| issue_sub | output | 2 | Thread sub-group index (0..3) |
| issue_pc | output | 16 | Instruction counter of the issuing warp |
| lane_en | output | 8 | Lane enables for this sub-cycle |

## Verification
Fine-grain rotation is driven with three warps that have distinct masks and counters, launched one by one while issue is already running. The expected order 0, 5, 23, 0 separates true round-robin from a lowest-index pick, and the counter on the second visit to warp 0 shows that the counter advances.

A short stall raised while warp 5 is in sub-cycle 0 separates boundary-only switching from immediate preemption. Watching the following rotation shows whether the stalled warp is skipped.

In coarse mode, two ready warps are used to tell apart three behaviours: staying with the owned warp, idling on a short stall, and switching to warp 7 only after a long stall. Retiring every warp checks the idle indication.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } sched_state_t;

endpackage

// File: rtl/warp_ctx_table.sv
module warp_ctx_table #(
    parameter int NUM_WARPS = 24,
    parameter int THREADS   = 32,
    parameter int PC_W      = 16,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_en,
    input  logic [WID_W-1:0]   launch_id,
    input  logic [PC_W-1:0]    launch_pc,
    input  logic [THREADS-1:0] launch_mask,
    input  logic               retire_en,
    input  logic [WID_W-1:0]   retire_id,
    input  logic               stall_en,
    input  logic [WID_W-1:0]   stall_id,
    input  logic               stall_long,
    input  logic               wake_en,
    input  logic [WID_W-1:0]   wake_id,
    input  logic               adv_en,
    input  logic [WID_W-1:0]   adv_id,
    input  logic [WID_W-1:0]   rd_id,
    output logic [PC_W-1:0]    rd_pc,
    output logic [THREADS-1:0] rd_mask,
    output logic [NUM_WARPS-1:0] valid_o,
    output logic [NUM_WARPS-1:0] short_o,
    output logic [NUM_WARPS-1:0] long_o,
    output logic [NUM_WARPS-1:0] ready_o
);

    logic [PC_W-1:0]    pc_arr   [NUM_WARPS];
    logic [THREADS-1:0] mask_arr [NUM_WARPS];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_ctx
        logic               vld_r;
        logic               shs_r;
        logic               lgs_r;
        logic [PC_W-1:0]    pc_r;
        logic [THREADS-1:0] msk_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
                shs_r <= 1'b0;
                lgs_r <= 1'b0;
                pc_r  <= '0;
                msk_r <= '0;
            end else begin
                if (adv_en && adv_id == WID_W'(w)) begin
                    pc_r <= pc_r + 1'b1;
                end
                if (stall_en && stall_id == WID_W'(w)) begin
                    if (stall_long) begin
                        lgs_r <= 1'b1;
                    end else begin
                        shs_r <= 1'b1;
                    end
                end
                if (wake_en && wake_id == WID_W'(w)) begin
                    shs_r <= 1'b0;
                    lgs_r <= 1'b0;
                end
                if (retire_en && retire_id == WID_W'(w)) begin
                    vld_r <= 1'b0;
                end
                if (launch_en && launch_id == WID_W'(w)) begin
                    vld_r <= 1'b1;
                    shs_r <= 1'b0;
                    lgs_r <= 1'b0;
                    pc_r  <= launch_pc;
                    msk_r <= launch_mask;
                end
            end
        end

        assign valid_o[w]  = vld_r;
        assign short_o[w]  = shs_r;
        assign long_o[w]   = lgs_r;
        assign ready_o[w]  = vld_r & ~shs_r & ~lgs_r;
        assign pc_arr[w]   = pc_r;
        assign mask_arr[w] = msk_r;
    end

    assign rd_pc   = pc_arr[rd_id];
    assign rd_mask = mask_arr[rd_id];

endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
    parameter int NUM_WARPS = 24,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] ready_i,
    input  logic [WID_W-1:0]     base_i,
    output logic                 found_o,
    output logic [WID_W-1:0]     pick_o
);

    always_comb begin
        int idx;
        found_o = 1'b0;
        pick_o  = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            idx = (int'(base_i) + k) % NUM_WARPS;
            if (!found_o && ready_i[idx]) begin
                found_o = 1'b1;
                pick_o  = WID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_lane_gate.sv
module warp_lane_gate #(
    parameter int THREADS   = 32,
    parameter int LANES     = 8,
    localparam int SUBCYC   = THREADS / LANES,
    localparam int SUB_W    = $clog2(SUBCYC)
) (
    input  logic               en_i,
    input  logic [SUB_W-1:0]   sub_i,
    input  logic [THREADS-1:0] mask_i,
    output logic [LANES-1:0]   lanes_o
);

    logic [LANES-1:0] slice [SUBCYC];
    logic [LANES-1:0] sel;

    for (genvar s = 0; s < SUBCYC; s++) begin : g_slice
        assign slice[s] = mask_i[s*LANES +: LANES];
    end

    assign sel = slice[sub_i];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes_o[g] = en_i & sel[g];
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS = 24,
    parameter int THREADS   = 32,
    parameter int LANES     = 8,
    parameter int PC_W      = 16,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int SUBCYC   = THREADS / LANES,
    localparam int SUB_W    = $clog2(SUBCYC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               coarse_mode,
    input  logic               launch_en,
    input  logic [WID_W-1:0]   launch_id,
    input  logic [PC_W-1:0]    launch_pc,
    input  logic [THREADS-1:0] launch_mask,
    input  logic               retire_en,
    input  logic [WID_W-1:0]   retire_id,
    input  logic               stall_en,
    input  logic [WID_W-1:0]   stall_id,
    input  logic               stall_long,
    input  logic               wake_en,
    input  logic [WID_W-1:0]   wake_id,
    output logic               issue_valid,
    output logic [WID_W-1:0]   issue_warp,
    output logic [SUB_W-1:0]   issue_sub,
    output logic [PC_W-1:0]    issue_pc,
    output logic [LANES-1:0]   lane_en
);
    import warp_sched_pkg::*;

    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(SUBCYC - 1);
    localparam logic [WID_W-1:0] WARP_LAST = WID_W'(NUM_WARPS - 1);

    sched_state_t      state_q, state_d;
    logic [WID_W-1:0]  cur_q, cur_d;
    logic [SUB_W-1:0]  sub_q, sub_d;
    logic              own_q, own_d;

    logic [NUM_WARPS-1:0] valid_v, short_v, long_v, ready_v;
    logic [PC_W-1:0]      cur_pc;
    logic [THREADS-1:0]   cur_mask;
    logic                 pick_found;
    logic [WID_W-1:0]     pick_id;
    logic                 boundary;
    logic                 group_done;
    logic                 cur_keep;

    assign group_done = (state_q == ST_ISSUE) && (sub_q == SUB_LAST);
    assign boundary   = (state_q != ST_ISSUE) || (sub_q == SUB_LAST);
    assign cur_keep   = coarse_mode && own_q && valid_v[cur_q] && !long_v[cur_q];

    warp_ctx_table #(
        .NUM_WARPS (NUM_WARPS),
        .THREADS   (THREADS),
        .PC_W      (PC_W)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_en   (launch_en),
        .launch_id   (launch_id),
        .launch_pc   (launch_pc),
        .launch_mask (launch_mask),
        .retire_en   (retire_en),
        .retire_id   (retire_id),
        .stall_en    (stall_en),
        .stall_id    (stall_id),
        .stall_long  (stall_long),
        .wake_en     (wake_en),
        .wake_id     (wake_id),
        .adv_en      (group_done),
        .adv_id      (cur_q),
        .rd_id       (cur_q),
        .rd_pc       (cur_pc),
        .rd_mask     (cur_mask),
        .valid_o     (valid_v),
        .short_o     (short_v),
        .long_o      (long_v),
        .ready_o     (ready_v)
    );

    warp_rr_pick #(
        .NUM_WARPS (NUM_WARPS)
    ) u_pick (
        .ready_i (ready_v),
        .base_i  (cur_q),
        .found_o (pick_found),
        .pick_o  (pick_id)
    );

    warp_lane_gate #(
        .THREADS (THREADS),
        .LANES   (LANES)
    ) u_gate (
        .en_i    (state_q == ST_ISSUE),
        .sub_i   (sub_q),
        .mask_i  (cur_mask),
        .lanes_o (lane_en)
    );

    // Next-state decision: only at group boundaries.
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        sub_d   = sub_q;
        own_d   = own_q;
        if (!boundary) begin
            sub_d = sub_q + 1'b1;
        end else if (cur_keep) begin
            sub_d = '0;
            if (short_v[cur_q]) begin
                state_d = ST_HOLD;
            end else begin
                state_d = ST_ISSUE;
            end
        end else if (pick_found) begin
            state_d = ST_ISSUE;
            cur_d   = pick_id;
            sub_d   = '0;
            own_d   = 1'b1;
        end else begin
            state_d = ST_IDLE;
            sub_d   = '0;
            own_d   = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= WARP_LAST;
            sub_q   <= '0;
            own_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            sub_q   <= sub_d;
            own_q   <= own_d;
        end
    end

    // Outputs from the present state.
    always_comb begin
        issue_valid = 1'b0;
        issue_warp  = cur_q;
        issue_sub   = sub_q;
        issue_pc    = cur_pc;
        unique case (state_q)
            ST_ISSUE: issue_valid = 1'b1;
            ST_HOLD:  issue_valid = 1'b0;
            ST_IDLE:  issue_valid = 1'b0;
            default:  issue_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
    parameter int NUM_WARPS = 24,
    parameter int THREADS   = 32,
    parameter int LANES     = 8,
    parameter int PC_W      = 16,
    localparam int WID_W    = $clog2(NUM_WARPS),
    localparam int SUBCYC   = THREADS / LANES,
    localparam int SUB_W    = $clog2(SUBCYC)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [WID_W-1:0] issue_warp,
    input logic [SUB_W-1:0] issue_sub,
    input logic [PC_W-1:0]  issue_pc,
    input logic [LANES-1:0] lane_en
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBCYC - 1);

    // R3
    sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_sub != SUB_LAST) |=>
            (issue_valid && issue_sub == $past(issue_sub) + 1'b1));

    // R3
    group_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_sub != SUB_LAST) |=>
            ($stable(issue_warp) && $stable(issue_pc)));

    // R11
    fresh_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!issue_valid || issue_sub == '0));

    // R10
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (lane_en == '0));

    // R5
    warp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_warp) < NUM_WARPS));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
    .NUM_WARPS (NUM_WARPS),
    .THREADS   (THREADS),
    .LANES     (LANES),
    .PC_W      (PC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_sub   (issue_sub),
    .issue_pc    (issue_pc),
    .lane_en     (lane_en)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        coarse_mode = 1'b0;
    logic        launch_en = 1'b0;
    logic [4:0]  launch_id = '0;
    logic [15:0] launch_pc = '0;
    logic [31:0] launch_mask = '0;
    logic        retire_en = 1'b0;
    logic [4:0]  retire_id = '0;
    logic        stall_en = 1'b0;
    logic [4:0]  stall_id = '0;
    logic        stall_long = 1'b0;
    logic        wake_en = 1'b0;
    logic [4:0]  wake_id = '0;
    logic        issue_valid;
    logic [4:0]  issue_warp;
    logic [1:0]  issue_sub;
    logic [15:0] issue_pc;
    logic [7:0]  lane_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    warp_issue_sched uut (
        .clk, .rst_n, .coarse_mode,
        .launch_en, .launch_id, .launch_pc, .launch_mask,
        .retire_en, .retire_id, .stall_en, .stall_id, .stall_long,
        .wake_en, .wake_id,
        .issue_valid, .issue_warp, .issue_sub, .issue_pc, .lane_en
    );

    localparam logic [31:0] M0  = 32'hFFFF_FFFF;
    localparam logic [31:0] M5  = 32'h3CF0_0FA5;
    localparam logic [31:0] M23 = 32'h8100_0001;

    // Expected fine-grain order, one entry per group: warp and counter.
    localparam int EXP_WARP [4] = '{0, 5, 23, 0};
    localparam int EXP_PC   [4] = '{100, 200, 300, 101};

    function automatic logic [31:0] mask_of(int w);
        if (w == 0)  return M0;
        if (w == 5)  return M5;
        if (w == 23) return M23;
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_ops();
        launch_en = 1'b0; retire_en = 1'b0; stall_en = 1'b0; wake_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_ops();
    endtask

    task automatic do_launch(input int id, input int pc, input logic [31:0] m);
        launch_en = 1'b1; launch_id = 5'(id); launch_pc = 16'(pc); launch_mask = m;
    endtask

    initial begin
        #(200000.0 * 5.0);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int other, idles, lane_bad, non2, got, sub_seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(issue_valid == 1'b0, "R1 valid in reset", int'(issue_valid), 0);
        chk(lane_en == 8'h00, "R1 lanes in reset", int'(lane_en), 0);
        rst_n = 1'b1;
        step();
        chk(issue_valid == 1'b0, "R1 valid after reset", int'(issue_valid), 0);

        // Fine-grain rotation table (R2 R3 R4 R5)
        do_launch(0, 100, M0);
        step();
        do_launch(5, 200, M5);
        @(posedge clk);
        @(negedge clk);
        idle_ops();
        for (int i = 0; i < 16; i++) begin
            if (i == 0) do_launch(23, 300, M23);
            chk(issue_valid == 1'b1, "R5 valid", int'(issue_valid), 1);
            chk(int'(issue_warp) == EXP_WARP[i/4], "R5 rr order", int'(issue_warp), EXP_WARP[i/4]);
            chk(int'(issue_sub) == i % 4, "R3 sub index", int'(issue_sub), i % 4);
            chk(int'(issue_pc) == EXP_PC[i/4], "R2 counter", int'(issue_pc), EXP_PC[i/4]);
            chk(lane_en == mask_of(EXP_WARP[i/4])[8*(i%4) +: 8], "R4 lane mask",
                int'(lane_en), int'(mask_of(EXP_WARP[i/4])[8*(i%4) +: 8]));
            step();
        end

        // Mid-group stall does not cut group (R11), then skipped (R6)
        chk(issue_warp == 5'd5 && issue_sub == 2'd0, "R11 setup", int'(issue_warp), 5);
        stall_en = 1'b1; stall_id = 5'd5; stall_long = 1'b0;
        step();
        for (int s = 1; s < 4; s++) begin
            chk(issue_valid && issue_warp == 5'd5 && int'(issue_sub) == s, "R11 group finishes",
                int'(issue_sub), s);
            step();
        end
        other = 0;
        got = 0;
        for (int c = 0; c < 24; c++) begin
            if (issue_valid && issue_warp == 5'd5) got++;
            if (issue_valid && (issue_warp == 5'd0 || issue_warp == 5'd23)) other++;
            step();
        end
        chk(got == 0, "R6 stalled warp skipped", got, 0);
        chk(other == 24, "R6 others issue", other, 24);

        // Retire all: idle (R10 R12)
        retire_en = 1'b1; retire_id = 5'd0;
        @(posedge clk); @(negedge clk);
        retire_id = 5'd5;
        @(posedge clk); @(negedge clk);
        retire_id = 5'd23;
        step();
        repeat (6) step();
        got = 0;
        for (int c = 0; c < 6; c++) begin
            if (issue_valid || lane_en != 8'h00) got++;
            step();
        end
        chk(got == 0, "R12 retired not issued", got, 0);
        chk(issue_valid == 1'b0 && lane_en == 8'h00, "R10 idle outputs", int'(lane_en), 0);

        // Coarse-grain (R7 R8 R9)
        coarse_mode = 1'b1;
        do_launch(2, 40, M0);
        step();
        do_launch(7, 70, M0);
        step();
        non2 = 0;
        got = 0;
        for (int c = 0; c < 16; c++) begin
            if (issue_valid) got++;
            if (issue_valid && issue_warp != 5'd2) non2++;
            step();
        end
        chk(non2 == 0, "R7 coarse stays", non2, 0);
        chk(got == 16, "R7 coarse issues", got, 16);

        stall_en = 1'b1; stall_id = 5'd2; stall_long = 1'b0;
        step();
        non2 = 0; idles = 0; lane_bad = 0;
        for (int c = 0; c < 12; c++) begin
            if (issue_valid && issue_warp != 5'd2) non2++;
            if (!issue_valid) idles++;
            if (!issue_valid && lane_en != 8'h00) lane_bad++;
            step();
        end
        chk(non2 == 0, "R8 no switch on short stall", non2, 0);
        chk(idles >= 8, "R8 lanes idle", idles, 8);
        chk(lane_bad == 0, "R8 idle lanes zero", lane_bad, 0);

        wake_en = 1'b1; wake_id = 5'd2;
        step();
        got = -1; sub_seen = -1;
        for (int c = 0; c < 6; c++) begin
            if (got < 0 && issue_valid) begin
                got = int'(issue_warp);
                sub_seen = int'(issue_sub);
            end
            step();
        end
        chk(got == 2, "R8 resumes same warp", got, 2);
        chk(sub_seen == 0, "R8 resumes at sub 0", sub_seen, 0);

        stall_en = 1'b1; stall_id = 5'd2; stall_long = 1'b1;
        step();
        got = -1; sub_seen = -1;
        for (int c = 0; c < 10; c++) begin
            if (got < 0 && issue_valid && issue_warp != 5'd2) begin
                got = int'(issue_warp);
                sub_seen = int'(issue_sub);
            end
            step();
        end
        chk(got == 7, "R9 switch on long stall", got, 7);
        chk(sub_seen == 0, "R9 new group at sub 0", sub_seen, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule